// File: doc/BRIEF.md
# Saturating Counter Receive Glitch Filter

This block cleans a single-bit serial receive line before a receiver consumes it. The raw line is first passed through a chain of flip-flops to bring it into the filter's clock domain. The synchronised level then steers an up/down counter on every rising clock edge. The counter rises while the line is high and falls while it is low. It stops at zero at the bottom and at a programmable ceiling at the top.

The filtered output is a latch with hysteresis. It goes to 1 only when the counter arrives at the ceiling, and to 0 only when the counter arrives at zero. At every count in between it keeps its last value. A noise pulse is therefore removed unless it lasts long enough, on balance, to carry the counter all the way to the opposite end. The ceiling is derived from a prescale field: the field is shifted right by three bits and ORed with 0x0F, so the ceiling is never below 15.

Top module: `rx_glitch_filter`

## Requirements
- R1: The raw line passes through two flip-flops before it steers the counter. After the counter has rested at one end, a constant opposite level that is applied just after clock edge n flips the output at edge n+T+2, and not earlier. T is the ceiling.
- R2: While the synchronised line is high and the count is below the ceiling, the count goes up by one per edge. While the line is low and the count is above zero, the count goes down by one per edge. Mixed runs therefore add up: 10 high samples, then 4 low, then 9 high reach a ceiling of 15.
- R3: The ceiling is T = (prescale >> 3) | 0x0F, taken over a 9-bit prescale field. 0x000 gives 15, 0x0A7 gives 31, 0x178 gives 47 and 0x1F8 gives 63.
- R4: When the count reaches the ceiling, the output is set to 1 on that edge. While the line stays high at the ceiling, the count stays there and never overflows.
- R5: When the count reaches zero, the output is cleared to 0 on that edge. While the line stays low at zero, the count stays at zero and never underflows.
- R6: Between zero and the ceiling the output holds its value. A pulse that does not carry the count to the opposite end leaves the output unchanged, whether the pulse goes high from the low rail or low from the high rail.
- R7: While rst_n is low, the count, the output and both synchroniser flops are 0.
- R8: If a lower prescale value leaves the count above the new ceiling, the count is treated as being at the ceiling. The output is set or held at 1, and only a decrement from the ceiling follows. A later low level clears the output after exactly T+2 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock; everything acts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Unsynchronised receive line from the pad |
| prescale | input | PRE_W (9) | Prescale field that sets the ceiling |
| rx_filt | output | 1 | Filtered receive bit |

## Verification
The bench builds the block with its default parameters: a 9-bit prescale field, a 6-bit counter and two synchroniser stages. With these defaults every ceiling from 15 to 63 can be reached. The bench exercises the ceilings 15, 31, 47 and 63, and times the output flip to the exact edge for each one, which pins down both the ceiling formula and the synchroniser latency. Because the counter is 6 bits, the bench can raise the count to 63 and then lower the ceiling to 15. That puts the count above range, so the clamp rule can be observed at the output by the timing of the next fall.

// File: rtl/rx_glitch_filter.sv
module rx_glitch_filter #(
  parameter int PRE_W       = 9,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int FLOOR       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_raw,
  input  logic [PRE_W-1:0] prescale,
  output logic             rx_filt
);
  localparam logic [PRE_W-1:0] FLOOR_V = PRE_W'(FLOOR);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic [CNT_W-1:0]       cnt_q, cnt_d, top;
  logic                   above, at_top, at_zero, filt_d;

  assign top     = CNT_W'((prescale >> 3) | FLOOR_V);
  assign rx_s    = sync_q[SYNC_STAGES-1];
  assign above   = cnt_q > top;
  assign at_top  = cnt_q >= top;
  assign at_zero = cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw};

  always_comb begin
    if (rx_s)         cnt_d = at_top ? top : cnt_q + 1'b1;
    else if (at_zero) cnt_d = '0;
    else if (above)   cnt_d = top - 1'b1;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    if (cnt_d == top || above) filt_d = 1'b1;
    else if (cnt_d == '0)      filt_d = 1'b0;
    else                       filt_d = rx_filt;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      rx_filt <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rx_filt <= filt_d;
    end
endmodule

module rx_glitch_filter_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_s,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] top,
  input logic             rx_filt
);
  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_s && cnt_q < top) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_s && cnt_q != '0 && cnt_q <= top) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_s && cnt_q >= top) |=> cnt_q == $past(top));

  p_set_at_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_s && cnt_q == top) |=> rx_filt);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_s && cnt_q == '0) |=> cnt_q == '0);

  p_clear_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_filt) |-> cnt_q == '0);

  p_rise_only_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_filt) |-> (cnt_q == $past(top) || $past(cnt_q > top)));

  p_over_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > top) |=> (rx_filt && cnt_q <= $past(top)));
endmodule

bind rx_glitch_filter rx_glitch_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .cnt_q(cnt_q), .top(top), .rx_filt(rx_filt)
);

// File: tb/tb_rx_glitch_filter.sv
module tb_rx_glitch_filter;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 9;

  logic          clk = 1'b0, rst_n = 1'b0, rx_raw = 1'b0;
  logic [PW-1:0] prescale = '0;
  logic          rx_filt;
  int            cyc = 0, total = 0, bad = 0;
  bit            done = 1'b0;
  int            q_cyc[$];
  bit            q_val[$];
  string         q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_glitch_filter dut (.clk(clk), .rst_n(rst_n), .rx_raw(rx_raw),
                        .prescale(prescale), .rx_filt(rx_filt));

  task automatic expect_at(int c, bit v, string r);
    q_cyc.push_back(c); q_val.push_back(v); q_req.push_back(r);
  endtask

  task automatic drive(bit v, int len);
    rx_raw = v;
    repeat (len) @(negedge clk);
  endtask

  always @(negedge clk)
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      int c; bit v; string r;
      c = q_cyc.pop_front(); v = q_val.pop_front(); r = q_req.pop_front();
      total++;
      if (c != cyc || rx_filt !== v) begin
        bad++;
        $display("FAIL %s edge %0d: rx_filt=%b expected %b (sampled at edge %0d)",
                 r, c, rx_filt, v, cyc);
      end
    end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    total++;
    if (rx_filt !== 1'b0) begin
      bad++; $display("FAIL R7 reset: rx_filt=%b expected 0", rx_filt);
    end
    rst_n = 1'b1;
    drive(0, 4);

    // R1 R4: rise from low rail with ceiling 15
    n = cyc; expect_at(n+16, 0, "R1"); expect_at(n+17, 1, "R1");
    drive(1, 30);
    expect_at(cyc+2, 1, "R4"); drive(1, 5);
    // R5: fall from high rail
    n = cyc; expect_at(n+16, 1, "R5"); expect_at(n+17, 0, "R5");
    drive(0, 30);
    // R6: high pulse of 14 from low rail
    n = cyc; expect_at(n+10, 0, "R6"); expect_at(n+17, 0, "R6"); expect_at(n+30, 0, "R6");
    drive(1, 14); drive(0, 25);
    // R2: 10 up, 4 down, then up to 15
    n = cyc; expect_at(n+24, 0, "R2"); expect_at(n+25, 1, "R2");
    drive(1, 10); drive(0, 4); drive(1, 20);
    // R6: low pulse of 14 from high rail
    n = cyc; expect_at(n+8, 1, "R6"); expect_at(n+20, 1, "R6");
    drive(0, 14); drive(1, 25);
    drive(0, 20);
    // R3: ceiling 47
    prescale = 9'h178;
    n = cyc; expect_at(n+48, 0, "R3"); expect_at(n+49, 1, "R3");
    drive(1, 60);
    n = cyc; expect_at(n+48, 1, "R3"); expect_at(n+49, 0, "R3");
    drive(0, 60);
    // R3: ceiling 31
    prescale = 9'h0A7;
    n = cyc; expect_at(n+32, 0, "R3"); expect_at(n+33, 1, "R3");
    drive(1, 40);
    n = cyc; expect_at(n+32, 1, "R3"); expect_at(n+33, 0, "R3");
    drive(0, 40);
    // R3: ceiling 63
    prescale = 9'h1F8;
    n = cyc; expect_at(n+64, 0, "R3"); expect_at(n+65, 1, "R3");
    drive(1, 70);
    // R8: lower ceiling to 15 with count at 63
    n = cyc; prescale = 9'h000;
    expect_at(n+1, 1, "R8"); expect_at(n+3, 1, "R8");
    drive(1, 5);
    n = cyc; expect_at(n+16, 1, "R8"); expect_at(n+17, 0, "R8");
    drive(0, 25);

    while (q_cyc.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule